// File: doc/BRIEF.md
# Masked-Write GPIO Port Register Bank

This block holds the pin-level control state for a group of general-purpose I/O ports: four 8-pin ports per bank, with a parameter for the number of banks. Each port has three writable registers and one read-only register. The writable registers are a pin-enable (configuration) register, a direction register and an output-data register. The read-only register returns the synchronized pad levels. Software reaches all of them through a plain synchronous 32-bit read/write port that carries an address, a write strobe, write data, a read strobe and registered read data.

Each writable register can also be reached through a masked alias. A write to the alias carries a per-pin select byte beside the value byte. Only the selected pins change, so one bus write can set or clear a single pin without a read-modify-write sequence, and software on other pins cannot race it. The block drives a pad only when that pin is both enabled and set as an output. Otherwise the pad is tri-stated. Pad inputs pass through a two-flop synchronizer before software can read them.

The block is pure register logic with no sequencing states. It has a single operating condition: out of reset, every pin is an undriven input.

Top module: `gpio_masked_bank`

## Requirements
- R1: After reset, every configuration, direction and output-data bit is 0, `pad_oe` and `pad_out` are all 0, and `bus_rdata` is 0.
- R2: A write to a direct register replaces all 8 bits of that register with `bus_wdata[7:0]`. The direct offsets are 0x00 (configuration), 0x10 (direction) and 0x20 (output data). A read of the same address returns the new value.
- R3: A write to a masked alias updates the matching register as follows. The aliases sit at 0x80 (configuration), 0x90 (direction) and 0xA0 (output data). Each pin whose select bit in `bus_wdata[15:8]` is 1 takes the matching bit of `bus_wdata[7:0]`. Every other pin keeps its value. `bus_wdata[31:16]` is ignored.
- R4: A read of a masked alias returns the same value as the matching direct register.
- R5: A register's byte address is bank×0x100 + port×4 + offset. `bus_addr[1:0]` is ignored. A write changes only the addressed port, and port p drives pins 8p to 8p+7.
- R6: A read of offset 0x30 returns the pad levels of the port in bits [7:0], one bit per pin. These levels come through a two-flop synchronizer. A pad change made before rising edge k is first captured by a read strobed at edge k+2. A read strobed at edge k+1 still returns the old level. Writes to offset 0x30 have no effect.
- R7: `pad_oe` for a pin is 1 only when both its configuration bit and its direction bit are 1. `pad_out` for a pin equals its output-data bit.
- R8: `bus_rdata` is loaded at the rising edge where `bus_rd` is 1, with bits [31:8] zero. It holds its value while `bus_rd` is 0.
- R9: A read returns 0, and a write has no effect, in two cases: offsets 0x40–0x70 and 0xB0–0xF0, and any bank number at or above NUM_BANKS.
- R10: A read strobed in the same cycle as a write to the same register returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address shared by reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; bits [15:8] are the pin selects for masked aliases |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_BANKS×32 | Asynchronous pad input levels |
| pad_out | output | NUM_BANKS×32 | Pad output values |
| pad_oe | output | NUM_BANKS×32 | Pad output enables (1 = driven) |

## Verification
Write results appear on `pad_oe` and `pad_out` right after the rising edge that takes the write. The bench therefore checks the pads at the falling edge that ends the write cycle. Read data is due one edge after the strobe. A scoreboard queues each expected word when the read is issued and compares it at the next falling edge. Pad-input results are due two edges later than register results. The bench checks both the too-early read and the on-time read against the old and new pad levels.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;

    localparam int PORTS_PER_BANK = 4;
    localparam int PINS_PER_PORT  = 8;
    localparam int WORD_W         = 32;

    // Low two bits of the offset nibble select the field; bit 3 selects the alias.
    typedef enum logic [1:0] {
        FLD_CFG = 2'd0,
        FLD_DIR = 2'd1,
        FLD_DAT = 2'd2,
        FLD_PIN = 2'd3
    } fld_e;

    function automatic logic [PINS_PER_PORT-1:0] merge_pins(
        input logic [PINS_PER_PORT-1:0] cur,
        input logic [PINS_PER_PORT-1:0] sel,
        input logic [PINS_PER_PORT-1:0] val
    );
        return (cur & ~sel) | (val & sel);
    endfunction

endpackage

// File: rtl/gpio_mw_decode.sv
module gpio_mw_decode
    import gpio_mw_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 12,
    localparam int NPORTS   = NUM_BANKS * PORTS_PER_BANK,
    localparam int PORT_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              masked,
    output fld_e              fld,
    output logic [PORT_W-1:0] port_idx
);

    logic [3:0]        off_nib;
    logic [1:0]        port_sel;
    logic [ADDR_W-9:0] bank_num;
    logic              off_ok;
    logic              bank_ok;

    always_comb begin
        off_nib  = addr[7:4];
        port_sel = addr[3:2];
        bank_num = addr[ADDR_W-1:8];
        masked   = off_nib[3];
        fld      = fld_e'(off_nib[1:0]);
        // Offsets with bit 2 set hold nothing; the input field has no alias.
        if (off_nib[2])
            off_ok = 1'b0;
        else if (off_nib[3])
            off_ok = (off_nib[1:0] != 2'b11);
        else
            off_ok = 1'b1;
        bank_ok  = (int'(bank_num) < NUM_BANKS);
        hit      = off_ok && bank_ok;
        port_idx = PORT_W'((int'(bank_num) * PORTS_PER_BANK) + int'(port_sel));
    end

endmodule

// File: rtl/gpio_mw_port.sv
module gpio_mw_port
    import gpio_mw_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     masked,
    input  fld_e                     fld,
    input  logic [WORD_W-1:0]        wdata,
    output logic [PINS_PER_PORT-1:0] cfg_q,
    output logic [PINS_PER_PORT-1:0] dir_q,
    output logic [PINS_PER_PORT-1:0] dat_q
);

    logic [PINS_PER_PORT-1:0] sel_bits;
    logic [PINS_PER_PORT-1:0] val_bits;

    always_comb begin
        val_bits = wdata[PINS_PER_PORT-1:0];
        sel_bits = masked ? wdata[2*PINS_PER_PORT-1:PINS_PER_PORT] : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            dir_q <= '0;
            dat_q <= '0;
        end else if (wr_en) begin
            unique case (fld)
                FLD_CFG: cfg_q <= merge_pins(cfg_q, sel_bits, val_bits);
                FLD_DIR: dir_q <= merge_pins(dir_q, sel_bits, val_bits);
                FLD_DAT: dat_q <= merge_pins(dat_q, sel_bits, val_bits);
                FLD_PIN: ;
            endcase
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cfg_q == '0 && dir_q == '0 && dat_q == '0));

    assert_masked_cfg_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && masked && fld == FLD_CFG) |=>
        (((cfg_q ^ $past(cfg_q)) & ~$past(wdata[15:8])) == '0));

    assert_masked_dir_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && masked && fld == FLD_DIR) |=>
        (((dir_q ^ $past(dir_q)) & ~$past(wdata[15:8])) == '0));

    assert_masked_dat_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && masked && fld == FLD_DAT) |=>
        (((dat_q ^ $past(dat_q)) & ~$past(wdata[15:8])) == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || fld == FLD_PIN) |=>
        ($stable(cfg_q) && $stable(dir_q) && $stable(dat_q)));

endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_d,
    output logic [WIDTH-1:0] sync_q
);

    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            sync_q <= '0;
        end else begin
            stage1 <= async_d;
            sync_q <= stage1;
        end
    end

endmodule

// File: rtl/gpio_masked_bank.sv
module gpio_masked_bank
    import gpio_mw_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 12,
    localparam int NPORTS   = NUM_BANKS * PORTS_PER_BANK,
    localparam int NPINS    = NPORTS * PINS_PER_PORT,
    localparam int PORT_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    logic              dec_hit;
    logic              dec_masked;
    fld_e              dec_fld;
    logic [PORT_W-1:0] dec_port;

    logic [PINS_PER_PORT-1:0] cfg_arr [NPORTS];
    logic [PINS_PER_PORT-1:0] dir_arr [NPORTS];
    logic [PINS_PER_PORT-1:0] dat_arr [NPORTS];
    logic [NPINS-1:0]         pin_sync;
    logic [31:0]              rd_word;

    gpio_mw_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr     (bus_addr),
        .hit      (dec_hit),
        .masked   (dec_masked),
        .fld      (dec_fld),
        .port_idx (dec_port)
    );

    gpio_mw_sync #(
        .WIDTH (NPINS)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_d (pad_in),
        .sync_q  (pin_sync)
    );

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        logic port_wr;

        always_comb port_wr = bus_wr && dec_hit && (dec_port == PORT_W'(g));

        gpio_mw_port u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (port_wr),
            .masked (dec_masked),
            .fld    (dec_fld),
            .wdata  (bus_wdata),
            .cfg_q  (cfg_arr[g]),
            .dir_q  (dir_arr[g]),
            .dat_q  (dat_arr[g])
        );

        always_comb begin
            pad_oe [g*PINS_PER_PORT +: PINS_PER_PORT] = cfg_arr[g] & dir_arr[g];
            pad_out[g*PINS_PER_PORT +: PINS_PER_PORT] = dat_arr[g];
        end
    end

    always_comb begin
        rd_word = '0;
        if (dec_hit) begin
            unique case (dec_fld)
                FLD_CFG: rd_word[PINS_PER_PORT-1:0] = cfg_arr[dec_port];
                FLD_DIR: rd_word[PINS_PER_PORT-1:0] = dir_arr[dec_port];
                FLD_DAT: rd_word[PINS_PER_PORT-1:0] = dat_arr[dec_port];
                FLD_PIN: rd_word[PINS_PER_PORT-1:0] =
                             pin_sync[int'(dec_port)*PINS_PER_PORT +: PINS_PER_PORT];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_word;
    end

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    assert_rdata_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_rdata[31:8] == 24'd0));

    assert_unmapped_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !dec_hit) |=> (bus_rdata == 32'd0));

endmodule

// File: tb/tb_gpio_masked_bank.sv
module tb_gpio_masked_bank;

    localparam int NB    = 2;
    localparam int AW    = 12;
    localparam int NPINS = NB * 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic             bus_wr = 1'b0;
    logic [31:0]      bus_wdata = '0;
    logic             bus_rd = 1'b0;
    logic [31:0]      bus_rdata;
    logic [NPINS-1:0] pad_in = '0;
    logic [NPINS-1:0] pad_out;
    logic [NPINS-1:0] pad_oe;

    int checks = 0;
    int failures = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    gpio_masked_bank #(.NUM_BANKS(NB), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [AW-1:0] adr(int p, int off);
        return AW'((p / 4) * 256 + (p % 4) * 4 + off);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor side of the scoreboard: read data is due one edge after the strobe.
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard-empty", 64'd1, 64'd0);
            end else begin
                chk(tag_q.pop_front(), {32'd0, bus_rdata}, {32'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr_rd(logic [AW-1:0] a, logic [31:0] d, logic [31:0] exp, string tag);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        chk("R1 pad_oe in reset", pad_oe, '0);
        chk("R1 pad_out in reset", pad_out, '0);
        chk("R1 rdata in reset", {32'd0, bus_rdata}, 64'd0);
        rst_n = 1'b1;
        idle(1);
        rd(adr(0, 8'h00), 32'h0, "R1 cfg p0");
        rd(adr(0, 8'h10), 32'h0, "R1 dir p0");
        rd(adr(7, 8'h20), 32'h0, "R1 dat p7");

        // R2 direct writes
        wr(adr(0, 8'h00), 32'hFFFF_FFFF);
        wr(adr(0, 8'h10), 32'h0000_00A5);
        wr(adr(0, 8'h20), 32'h1234_563C);
        rd(adr(0, 8'h00), 32'hFF, "R2 cfg readback");
        rd(adr(0, 8'h10), 32'hA5, "R2 dir readback");
        rd(adr(0, 8'h20), 32'h3C, "R2 dat readback");
        chk("R7 pad_oe p0", {56'd0, pad_oe[7:0]}, 64'hA5);
        chk("R7 pad_out p0", {56'd0, pad_out[7:0]}, 64'h3C);

        // R3 masked writes: (0x3C & ~0x0F) | (0xF0 & 0x0F) = 0x30
        wr(adr(0, 8'hA0), 32'hDEAD_0FF0);
        rd(adr(0, 8'h20), 32'h30, "R3 masked dat nibble");
        chk("R3 pad_out after masked", {56'd0, pad_out[7:0]}, 64'h30);
        wr(adr(0, 8'hA0), 32'h0000_00FF);
        rd(adr(0, 8'h20), 32'h30, "R3 masked dat empty select");
        wr(adr(0, 8'h90), 32'h0000_FF81);
        rd(adr(0, 8'h10), 32'h81, "R3 masked dir full select");

        // R4 alias reads
        rd(adr(0, 8'h80), 32'hFF, "R4 cfg alias read");
        rd(adr(0, 8'h90), 32'h81, "R4 dir alias read");
        rd(adr(0, 8'hA0), 32'h30, "R4 dat alias read");

        // R7 masked cfg clear of pin 7: cfg 0x7F, dir 0x81 -> oe 0x01
        wr(adr(0, 8'h80), 32'h0000_8000);
        chk("R7 pad_oe needs cfg and dir", {56'd0, pad_oe[7:0]}, 64'h01);

        // R5 addressing: port 5 = bank 1 port 1 at 0x104
        wr(adr(5, 8'h00), 32'h11);
        rd(12'h104, 32'h11, "R5 bank1 port1 cfg");
        rd(adr(1, 8'h00), 32'h0, "R5 bank0 port1 untouched");
        chk("R5 port5 not driven yet", {56'd0, pad_oe[47:40]}, 64'h0);
        wr(adr(5, 8'h10), 32'hFF);
        wr(adr(5, 8'h20), 32'h5A);
        chk("R5 port5 pads oe", {56'd0, pad_oe[47:40]}, 64'h11);
        chk("R5 port5 pads out", {56'd0, pad_out[47:40]}, 64'h5A);
        chk("R5 other ports idle", {8'd0, pad_oe[63:48], pad_oe[39:8]}, 64'h0);
        rd(adr(5, 8'h00) | 12'h003, 32'h11, "R5 low address bits ignored");

        // R6 synchronized input
        pad_in[7:0] = 8'hC3;
        pad_in[55:48] = 8'h69;
        idle(1);
        rd(adr(0, 8'h30), 32'h0, "R6 input one edge early");
        rd(adr(0, 8'h30), 32'hC3, "R6 input on time");
        rd(adr(6, 8'h30), 32'h69, "R6 input port6");
        wr(adr(0, 8'h30), 32'hFFFF_FF00);
        rd(adr(0, 8'h30), 32'hC3, "R6 write to input ignored");

        // R9 unmapped offsets and banks
        rd(adr(0, 8'h40), 32'h0, "R9 hole offset read");
        rd(adr(0, 8'hB0), 32'h0, "R9 input alias read");
        rd(12'h200, 32'h0, "R9 missing bank read");
        wr(adr(0, 8'h50), 32'h0000_FFFF);
        wr(12'h200, 32'h0000_00AA);
        wr(12'h2A0, 32'h0000_FFAA);
        rd(adr(0, 8'h00), 32'h7F, "R9 cfg p0 unchanged");
        rd(adr(0, 8'h20), 32'h30, "R9 dat p0 unchanged");
        chk("R9 pads unchanged", {56'd0, pad_out[7:0]}, 64'h30);

        // R8 hold
        rd(adr(0, 8'h10), 32'h81, "R8 setup read");
        bus_addr = adr(0, 8'h00);
        idle(2);
        chk("R8 rdata holds without strobe", {32'd0, bus_rdata}, 64'h81);

        // R10 read during write
        wr_rd(adr(0, 8'h20), 32'h0000_00EE, 32'h30, "R10 read returns pre-write");
        rd(adr(0, 8'h20), 32'hEE, "R10 write then landed");

        idle(2);
        chk("scoreboard drained", {32'd0, 32'(exp_q.size())}, 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule